// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block sits between two parallel buses, A and B, and moves data across in either direction. Each direction of each half of the data path has one storage element. That element can pass data straight through, hold what it last passed, or take a new value on a clock edge. Three controls per direction and half set its behaviour: a latch enable, a capture clock and an active-low output enable. The path is two 9-bit halves by default. Each half has its own set of controls, so the halves can be wired together as one wide transceiver or used as two narrow ones.

Both bus sides are tri-state drivers. Each driver also reports its drive state on a separate output, so the surrounding logic or a bench can watch for two drivers fighting on the same half. An active-low reset clears every storage element to zero. While reset is held, all drivers stay off.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its destination bus half follows the source bus half with no clock needed.
- R2: While the latch enable is low and the capture clock does not rise, the destination half keeps its value even when the source changes.
- R3: A rising edge of the capture clock while the latch enable is low loads the current source value, and the destination then shows it.
- R4: With the active-low output enable low, the destination half is driven and its drive flag is 1. With the output enable high, the half is high impedance (all Z) and the flag is 0.
- R5: The B-to-A direction works the same way as A-to-B, using its own latch enable, clock and output enable, and drives the A bus.
- R6: Control bit h (h = 0 or 1) governs only data bits h*9 to h*9+8. The other half is unaffected by it.
- R7: A rising clock edge while the latch enable is high has no effect of its own. After the latch enable falls, the element keeps the last value it passed through.
- R8: Reset clears every storage element to zero and turns every drive flag off, whatever the output enables are.
- R9: In correct use, the A-side and B-side drive flags of one half are never 1 together. If they are, that is bus contention and it is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_le | input | 2 | A-to-B latch enable, one per half |
| ab_clk | input | 2 | A-to-B capture clock, one per half |
| ab_oen | input | 2 | A-to-B active-low output enable, one per half |
| ba_le | input | 2 | B-to-A latch enable, one per half |
| ba_clk | input | 2 | B-to-A capture clock, one per half |
| ba_oen | input | 2 | B-to-A active-low output enable, one per half |
| a_bus | inout | 18 | A-side bus |
| b_bus | inout | 18 | B-side bus |
| a_drv | output | 2 | 1 while the block drives that half of the A bus |
| b_drv | output | 2 | 1 while the block drives that half of the B bus |

## Verification
Some properties are checked continuously:
- Each drive flag implies that its output enable is low.
- Reset forces every flag off.
- The two sides of a half never drive together.
- At each capture-clock edge, a transparent element matches its source, and a registered element shows the value sampled at the previous edge.

Other behaviours appear only in the bench's directed scenarios, because they depend on the order of control events between clock edges:
- holding with no edge
- keeping the last passed value after the latch enable falls
- a clock edge while transparent having no effect
- high impedance on the bus
- the independence of the two halves

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int HW     = 9,
  parameter int HALVES = 2,
  localparam int W     = HW * HALVES
) (
  input  logic              rst_n,
  input  logic [HALVES-1:0] ab_le,
  input  logic [HALVES-1:0] ab_clk,
  input  logic [HALVES-1:0] ab_oen,
  input  logic [HALVES-1:0] ba_le,
  input  logic [HALVES-1:0] ba_clk,
  input  logic [HALVES-1:0] ba_oen,
  inout  wire  [W-1:0]      a_bus,
  inout  wire  [W-1:0]      b_bus,
  output logic [HALVES-1:0] a_drv,
  output logic [HALVES-1:0] b_drv
);

  assign a_drv = {HALVES{rst_n}} & ~ba_oen;
  assign b_drv = {HALVES{rst_n}} & ~ab_oen;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HW-1:0] ab_din, ab_lat, ab_reg, ab_q;
    logic [HW-1:0] ba_din, ba_lat, ba_reg, ba_q;
    logic          ab_use_reg, ba_use_reg;

    assign ab_din = a_bus[h*HW +: HW];
    assign ba_din = b_bus[h*HW +: HW];

    always_latch begin
      if (!rst_n)       ab_lat = '0;
      else if (ab_le[h]) ab_lat = ab_din;
    end

    always_ff @(posedge ab_clk[h] or negedge rst_n) begin
      if (!rst_n)         ab_reg <= '0;
      else if (!ab_le[h]) ab_reg <= ab_din;
    end

    always_ff @(posedge ab_clk[h] or posedge ab_le[h] or negedge rst_n) begin
      if (!rst_n)        ab_use_reg <= 1'b0;
      else if (ab_le[h]) ab_use_reg <= 1'b0;
      else               ab_use_reg <= 1'b1;
    end

    always_latch begin
      if (!rst_n)       ba_lat = '0;
      else if (ba_le[h]) ba_lat = ba_din;
    end

    always_ff @(posedge ba_clk[h] or negedge rst_n) begin
      if (!rst_n)         ba_reg <= '0;
      else if (!ba_le[h]) ba_reg <= ba_din;
    end

    always_ff @(posedge ba_clk[h] or posedge ba_le[h] or negedge rst_n) begin
      if (!rst_n)        ba_use_reg <= 1'b0;
      else if (ba_le[h]) ba_use_reg <= 1'b0;
      else               ba_use_reg <= 1'b1;
    end

    assign ab_q = ab_le[h] ? ab_din : (ab_use_reg ? ab_reg : ab_lat);
    assign ba_q = ba_le[h] ? ba_din : (ba_use_reg ? ba_reg : ba_lat);

    assign b_bus[h*HW +: HW] = b_drv[h] ? ab_q : {HW{1'bz}};
    assign a_bus[h*HW +: HW] = a_drv[h] ? ba_q : {HW{1'bz}};
  end

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int HW     = 9,
  parameter int HALVES = 2,
  localparam int W     = HW * HALVES
) (
  input logic              rst_n,
  input logic [HALVES-1:0] ab_le,
  input logic [HALVES-1:0] ab_clk,
  input logic [HALVES-1:0] ab_oen,
  input logic [HALVES-1:0] ba_le,
  input logic [HALVES-1:0] ba_clk,
  input logic [HALVES-1:0] ba_oen,
  input wire  [W-1:0]      a_bus,
  input wire  [W-1:0]      b_bus,
  input logic [HALVES-1:0] a_drv,
  input logic [HALVES-1:0] b_drv
);

  always_comb begin
    if (!rst_n) a_r8_reset_quiet: assert (a_drv == '0 && b_drv == '0);
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    always_comb begin
      if (b_drv[h]) a_r4_b_drive_needs_oe: assert (ab_oen[h] == 1'b0);
      if (a_drv[h]) a_r5_a_drive_needs_oe: assert (ba_oen[h] == 1'b0);
      a_r9_one_driver: assert (!(a_drv[h] && b_drv[h]));
    end

    a_r1_ab_transparent: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
      (ab_le[h] && b_drv[h]) |-> (b_bus[h*HW +: HW] === a_bus[h*HW +: HW]));

    a_r3_ab_capture: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
      ($past(rst_n) && !ab_le[h] && $past(!ab_le[h]) && b_drv[h])
        |-> (b_bus[h*HW +: HW] === $past(a_bus[h*HW +: HW])));

    a_r5_ba_transparent: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
      (ba_le[h] && a_drv[h]) |-> (a_bus[h*HW +: HW] === b_bus[h*HW +: HW]));

    a_r5_ba_capture: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
      ($past(rst_n) && !ba_le[h] && $past(!ba_le[h]) && a_drv[h])
        |-> (a_bus[h*HW +: HW] === $past(b_bus[h*HW +: HW])));
  end

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HW(HW), .HALVES(HALVES)) u_chk (.*);

// File: tb/sim_ubt_xcvr.sv
module sim_ubt_xcvr;
  localparam int CLK_P = 10;
  localparam int HW = 9;
  localparam int W = 18;

  logic tick = 1'b0;
  always #(CLK_P/2) tick = ~tick;

  logic       rst_n;
  logic [1:0] ab_le, ab_clk, ab_oen, ba_le, ba_clk, ba_oen;
  logic [1:0] a_drv, b_drv;
  logic [1:0] a_en, b_en;
  logic [W-1:0] a_val, b_val;
  wire  [W-1:0] a_bus, b_bus;

  for (genvar h = 0; h < 2; h++) begin : g_drv
    assign a_bus[h*HW +: HW] = a_en[h] ? a_val[h*HW +: HW] : {HW{1'bz}};
    assign b_bus[h*HW +: HW] = b_en[h] ? b_val[h*HW +: HW] : {HW{1'bz}};
  end

  ubt_xcvr u0 (
    .rst_n(rst_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_oen(ab_oen),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oen(ba_oen),
    .a_bus(a_bus), .b_bus(b_bus), .a_drv(a_drv), .b_drv(b_drv)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  localparam logic [HW-1:0] ZZ = {HW{1'bz}};

  task automatic step();
    @(negedge tick);
  endtask

  task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] bh(input int h);
    return b_bus[h*HW +: HW];
  endfunction

  function automatic logic [HW-1:0] ah(input int h);
    return a_bus[h*HW +: HW];
  endfunction

  task automatic one_way();
    for (int h = 0; h < 2; h++) chk("R9 one driver per half", HW'(a_drv[h] & b_drv[h]), '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ab_le = '0; ab_clk = '0; ab_oen = '1;
    ba_le = '0; ba_clk = '0; ba_oen = '1;
    a_en = '0; b_en = '0; a_val = '0; b_val = '0;
    step();
    chk("R8 drive flags off in reset", HW'({a_drv, b_drv}), '0);
    chk("R8 B bus undriven in reset", bh(0), ZZ);
    ab_oen = 2'b00; ba_oen = 2'b00; step();
    chk("R8 enables ignored in reset", HW'({a_drv, b_drv}), '0);
    ab_oen = '1; ba_oen = '1; step();
    rst_n = 1'b1; step();
    a_en = 2'b11; a_val = {9'h0AA, 9'h1FF}; ab_oen[0] = 1'b0; step();
    chk("R8 storage cleared by reset", bh(0), '0);
    ab_oen[0] = 1'b1; step();
  endtask

  task automatic t_transparent();
    ab_le[0] = 1'b1; ab_oen[0] = 1'b0; a_val[8:0] = 9'h155; step();
    chk("R1 B follows A", bh(0), 9'h155);
    chk("R4 drive flag on", HW'(b_drv[0]), 9'd1);
    a_val[8:0] = 9'h0F3; step();
    chk("R1 B follows new A", bh(0), 9'h0F3);
    one_way();
  endtask

  task automatic t_hold_and_load();
    ab_le[0] = 1'b0; step();
    a_val[8:0] = 9'h12C; step();
    chk("R2 held after latch closes", bh(0), 9'h0F3);
    ab_clk[0] = 1'b1; step();
    chk("R3 clock edge loads A", bh(0), 9'h12C);
    ab_clk[0] = 1'b0; a_val[8:0] = 9'h007; step();
    chk("R2 hold with static clock", bh(0), 9'h12C);
    ab_clk[0] = 1'b1; step();
    chk("R3 second edge loads A", bh(0), 9'h007);
    ab_clk[0] = 1'b0; step();
  endtask

  task automatic t_edge_while_open();
    ab_le[0] = 1'b1; a_val[8:0] = 9'h0E1; step();
    ab_clk[0] = 1'b1; step();
    a_val[8:0] = 9'h19B; step();
    chk("R7 still transparent after edge", bh(0), 9'h19B);
    ab_clk[0] = 1'b0; step();
    ab_le[0] = 1'b0; step();
    a_val[8:0] = 9'h044; step();
    chk("R7 keeps last passed value", bh(0), 9'h19B);
  endtask

  task automatic t_hiz();
    ab_oen[0] = 1'b1; step();
    chk("R4 B half high impedance", bh(0), ZZ);
    chk("R4 drive flag off", HW'(b_drv[0]), '0);
    ab_oen[0] = 1'b0; step();
    chk("R4 stored value back on bus", bh(0), 9'h19B);
  endtask

  task automatic t_halves();
    ab_le[0] = 1'b1; ab_le[1] = 1'b0; ab_oen[1] = 1'b0;
    a_val = {9'h111, 9'h0CC}; step();
    chk("R6 half0 transparent", bh(0), 9'h0CC);
    chk("R6 half1 still reset value", bh(1), '0);
    ab_clk[1] = 1'b1; step();
    chk("R6 half1 loads on its clock", bh(1), 9'h111);
    ab_clk[1] = 1'b0; a_val = {9'h1E0, 9'h033}; step();
    chk("R6 half0 follows alone", bh(0), 9'h033);
    chk("R6 half1 held", bh(1), 9'h111);
    one_way();
    ab_oen = '1; ab_le = '0; step();
  endtask

  task automatic t_reverse();
    a_en = '0; b_en = 2'b11; b_val = {9'h0A5, 9'h15A};
    ba_le[1] = 1'b1; ba_oen[1] = 1'b0; step();
    chk("R5 A follows B", ah(1), 9'h0A5);
    chk("R5 A half0 undriven", ah(0), ZZ);
    chk("R5 drive flags", HW'(a_drv), 9'd2);
    ba_le[1] = 1'b0; step();
    b_val[17:9] = 9'h1C3; step();
    chk("R5 A held", ah(1), 9'h0A5);
    ba_clk[1] = 1'b1; step();
    chk("R5 A loads on clock", ah(1), 9'h1C3);
    ba_clk[1] = 1'b0; step();
    one_way();
    ba_oen = '1; step();
    chk("R5 A released", ah(1), ZZ);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold_and_load();
    t_edge_while_open();
    t_hiz();
    t_halves();
    t_reverse();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tick);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule